// File: doc/BRIEF.md
# Prioritized Prefetch Request Queue

This block holds pending prefetch candidates in a bounded list ordered by a signed priority, highest first. A generator upstream offers one candidate per cycle: a block-aligned physical address, a priority and a secure flag. The queue keeps each accepted candidate until a consumer pops it through the issue port. The head entry is shown on the issue port only after a fixed number of cycles has passed since its insertion.

When a candidate arrives, the queue first compares it against its stored entries. An address that is already queued does not create a second entry. Instead, a higher priority raises the stored entry to the new value and moves it forward in the list. A candidate that is not a duplicate is sent to an external cache and miss-queue lookup when snooping is on. A hit there drops it. When there is no room, the queue makes space by discarding the oldest entry of its lowest priority level.

All four outcomes (buffer hit, eviction on full, snoop drop, issue) are counted. A pop and an insert in the same cycle are both handled, and the pop takes effect first.

Top module: `pf_prio_queue`

## Requirements
- R1: After reset the queue is empty: issueValid is 0, all four counters read 0 and lookupReq is 0 while no candidate is offered.
- R2: Entries issue in order of descending signed priority. A new entry goes after every stored entry whose priority is greater than or equal to its own, so equal priorities issue first-in first-out.
- R3: An entry inserted at a clock edge becomes ready after LATENCY cycles counted from its insertion cycle. With the default LATENCY of 1, issueValid is 1 in the cycle right after that edge, and issueAddr, issuePrio and issueSecure then show the head entry.
- R4: With cfgFilterEn at 1, a candidate whose address and secure flag both equal those of a stored entry adds no entry and increments bufHitCnt by one. The same address with a different secure flag is not a duplicate.
- R5: On such a duplicate, a strictly higher new priority replaces the stored one and moves the entry behind all entries of equal or higher priority. An equal or lower priority leaves the stored entry, its value and its position unchanged.
- R6: With cfgFilterEn at 0, a repeated address is stored as a further independent entry and bufHitCnt does not change.
- R7: When a non-duplicate candidate arrives at a full queue, the queue first removes the entry of the lowest priority level that was placed earliest in that level, then inserts the candidate, and evictCnt increments by one.
- R8: lookupReq equals insValid AND cfgSnoopEn. A non-duplicate candidate with cfgSnoopEn at 1 and lookupHit at 1 is dropped and snoopDropCnt increments. With cfgSnoopEn at 0, lookupHit is ignored. The duplicate check comes before the snoop check.
- R9: issueReady while issueValid is 1 removes the head entry and increments issuedCnt. issueReady while issueValid is 0 changes nothing.
- R10: A pop and an insert in the same cycle are both applied, with the pop first. A full queue that pops and inserts in one cycle therefore evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgFilterEn | input | 1 | Enable duplicate filtering |
| cfgSnoopEn | input | 1 | Enable the cache and miss-queue lookup |
| insValid | input | 1 | Candidate offered this cycle |
| insAddr | input | ADDR_W | Block-aligned physical address of the candidate |
| insPrio | input | PRIO_W | Signed priority of the candidate |
| insSecure | input | 1 | Secure flag of the candidate |
| lookupReq | output | 1 | Lookup requested for the offered candidate |
| lookupAddr | output | ADDR_W | Address to look up |
| lookupSecure | output | 1 | Secure flag to look up |
| lookupHit | input | 1 | Same-cycle lookup result: present in cache or miss queue |
| issueValid | output | 1 | Head entry is ready to issue |
| issueReady | input | 1 | Consumer takes the head entry |
| issueAddr | output | ADDR_W | Address of the head entry |
| issuePrio | output | PRIO_W | Priority of the head entry |
| issueSecure | output | 1 | Secure flag of the head entry |
| bufHitCnt | output | CNT_W | Count of duplicates found in the queue |
| evictCnt | output | CNT_W | Count of entries removed because the queue was full |
| snoopDropCnt | output | CNT_W | Count of candidates dropped on a lookup hit |
| issuedCnt | output | CNT_W | Count of entries popped |

## Verification
Each insert, promotion, eviction and pop is applied at the clock edge where it is presented. The new head, issueValid and all four counters are therefore due in the cycle after that edge, and lookupReq is due combinationally in the cycle of the offer. The bench drives every input on a falling edge and samples on the next falling edge, half a cycle after the rising edge that carries the effect. The head address and priority are checked before a pop is driven, and a pop is only driven once issueValid has been seen. Priority order, promotion and eviction are all judged by the sequence of entries that come out of the issue port.

// File: rtl/pf_prio_queue_pkg.sv
package pf_prio_queue_pkg;

  // Strobes from the control to the datapath for the insert path.
  typedef struct packed {
    logic remove;          // take one entry out of the post-pop list
    logic removeMatch;     // 1: remove the matched entry, 0: remove the eviction victim
    logic insert;          // place one entry into the list
    logic insertPromoted;  // 1: re-place the matched entry, 0: place the candidate
  } ppqStrobe_t;

endpackage

// File: rtl/pf_prio_queue_dp.sv
module pf_prio_queue_dp
  import pf_prio_queue_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 32,
  parameter int LATENCY = 1,
  parameter int TIME_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              popGo,
  input  ppqStrobe_t        stb,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [PRIO_W-1:0] insPrio,
  input  logic              insSecure,
  output logic              headReady,
  output logic [ADDR_W-1:0] headAddr,
  output logic [PRIO_W-1:0] headPrio,
  output logic              headSecure,
  output logic              matchFound,
  output logic [PRIO_W-1:0] matchPrio,
  output logic              postPopFull
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [PRIO_W-1:0] prio;
    logic              secure;
    logic [TIME_W-1:0] readyAt;
  } entry_t;

  entry_t            slotQ   [DEPTH];
  entry_t            popArr  [DEPTH];
  entry_t            remArr  [DEPTH];
  entry_t            nextArr [DEPTH];
  logic [CNT_W-1:0]  fillQ;
  logic [TIME_W-1:0] nowQ;

  logic [CNT_W-1:0]  popFill;
  logic [CNT_W-1:0]  remFill;
  logic [CNT_W-1:0]  nextFill;
  logic [IDX_W-1:0]  matchIdx;
  logic [IDX_W-1:0]  evictIdx;
  logic [IDX_W-1:0]  remIdx;
  logic [IDX_W-1:0]  insPos;
  logic [PRIO_W-1:0] tailPrio;
  entry_t            newEnt;

  // Head status, computed from state only
  assign headReady  = (fillQ != '0) && ($signed(nowQ - slotQ[0].readyAt) >= 0);
  assign headAddr   = slotQ[0].addr;
  assign headPrio   = slotQ[0].prio;
  assign headSecure = slotQ[0].secure;

  assign popFill     = fillQ - CNT_W'(popGo);
  assign postPopFull = (popFill == CNT_W'(DEPTH));
  assign remFill     = popFill - CNT_W'(stb.remove);
  assign nextFill    = remFill + CNT_W'(stb.insert);

  // Duplicate search on the list as it stands after a pop
  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < popFill) && (popArr[i].addr == insAddr) &&
          (popArr[i].secure == insSecure)) begin
        matchFound = 1'b1;
        matchIdx   = IDX_W'(i);
      end
    end
  end
  assign matchPrio = popArr[matchIdx].prio;

  // Eviction victim: front-most entry of the tail's priority level (only used when full)
  assign tailPrio = popArr[DEPTH-1].prio;
  always_comb begin
    evictIdx = IDX_W'(DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (popArr[i].prio == tailPrio) evictIdx = IDX_W'(i);
    end
  end

  assign remIdx = stb.removeMatch ? matchIdx : evictIdx;

  // Entry to place: promoted copy or fresh candidate
  always_comb begin
    if (stb.insertPromoted) begin
      newEnt      = popArr[matchIdx];
      newEnt.prio = insPrio;
    end else begin
      newEnt.addr    = insAddr;
      newEnt.prio    = insPrio;
      newEnt.secure  = insSecure;
      newEnt.readyAt = nowQ + TIME_W'(LATENCY);
    end
  end

  // Insert position: in front of the first strictly lower priority
  always_comb begin
    insPos = IDX_W'(remFill);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < remFill) && ($signed(remArr[i].prio) < $signed(newEnt.prio)))
        insPos = IDX_W'(i);
    end
  end

  // Three shift stages per slot: pop, remove, insert
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g < DEPTH - 1) begin : g_mid
      assign popArr[g] = popGo ? slotQ[g+1] : slotQ[g];
      assign remArr[g] = (stb.remove && (IDX_W'(g) >= remIdx)) ? popArr[g+1] : popArr[g];
    end else begin : g_last
      assign popArr[g] = slotQ[g];
      assign remArr[g] = popArr[g];
    end
    if (g == 0) begin : g_first
      assign nextArr[g] = (stb.insert && (insPos == '0)) ? newEnt : remArr[g];
    end else begin : g_rest
      assign nextArr[g] = (!stb.insert || (IDX_W'(g) < insPos)) ? remArr[g] :
                          (IDX_W'(g) == insPos) ? newEnt : remArr[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillQ <= '0;
      nowQ  <= '0;
    end else begin
      fillQ <= nextFill;
      nowQ  <= nowQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slotQ[i] <= nextArr[i];
  end

endmodule

// File: rtl/pf_prio_queue_ctrl.sv
module pf_prio_queue_ctrl
  import pf_prio_queue_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgFilterEn,
  input  logic              cfgSnoopEn,
  input  logic              insValid,
  input  logic [PRIO_W-1:0] insPrio,
  input  logic              lookupHit,
  input  logic              issueReady,
  input  logic              headReady,
  input  logic              matchFound,
  input  logic [PRIO_W-1:0] matchPrio,
  input  logic              postPopFull,
  output logic              popGo,
  output ppqStrobe_t        stb,
  output logic [CNT_W-1:0]  bufHitCnt,
  output logic [CNT_W-1:0]  evictCnt,
  output logic [CNT_W-1:0]  snoopDropCnt,
  output logic [CNT_W-1:0]  issuedCnt
);

  logic dupHit;
  logic snoopDrop;
  logic newIns;
  logic promote;
  logic evictGo;

  assign popGo = headReady && issueReady;

  always_comb begin
    dupHit    = insValid && cfgFilterEn && matchFound;
    snoopDrop = insValid && !dupHit && cfgSnoopEn && lookupHit;
    newIns    = insValid && !dupHit && !snoopDrop;
    promote   = dupHit && ($signed(insPrio) > $signed(matchPrio));
    evictGo   = newIns && postPopFull;

    stb                = '0;
    stb.remove         = promote || evictGo;
    stb.removeMatch    = promote;
    stb.insert         = promote || newIns;
    stb.insertPromoted = promote;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bufHitCnt    <= '0;
      evictCnt     <= '0;
      snoopDropCnt <= '0;
      issuedCnt    <= '0;
    end else begin
      if (dupHit)    bufHitCnt    <= bufHitCnt + 1'b1;
      if (evictGo)   evictCnt     <= evictCnt + 1'b1;
      if (snoopDrop) snoopDropCnt <= snoopDropCnt + 1'b1;
      if (popGo)     issuedCnt    <= issuedCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pf_prio_queue.sv
module pf_prio_queue
  import pf_prio_queue_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 32,
  parameter int LATENCY = 1,
  parameter int TIME_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgFilterEn,
  input  logic              cfgSnoopEn,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [PRIO_W-1:0] insPrio,
  input  logic              insSecure,
  output logic              lookupReq,
  output logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupSecure,
  input  logic              lookupHit,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [PRIO_W-1:0] issuePrio,
  output logic              issueSecure,
  output logic [CNT_W-1:0]  bufHitCnt,
  output logic [CNT_W-1:0]  evictCnt,
  output logic [CNT_W-1:0]  snoopDropCnt,
  output logic [CNT_W-1:0]  issuedCnt
);

  if (DEPTH < 2) begin : g_depthChk
    $error("pf_prio_queue: DEPTH must be at least 2 so that eviction has a victim");
  end

  ppqStrobe_t        stb;
  logic              popGo;
  logic              headReady;
  logic              matchFound;
  logic [PRIO_W-1:0] matchPrio;
  logic              postPopFull;

  assign lookupReq    = insValid && cfgSnoopEn;
  assign lookupAddr   = insAddr;
  assign lookupSecure = insSecure;
  assign issueValid   = headReady;

  pf_prio_queue_ctrl #(
    .PRIO_W (PRIO_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgFilterEn  (cfgFilterEn),
    .cfgSnoopEn   (cfgSnoopEn),
    .insValid     (insValid),
    .insPrio      (insPrio),
    .lookupHit    (lookupHit),
    .issueReady   (issueReady),
    .headReady    (headReady),
    .matchFound   (matchFound),
    .matchPrio    (matchPrio),
    .postPopFull  (postPopFull),
    .popGo        (popGo),
    .stb          (stb),
    .bufHitCnt    (bufHitCnt),
    .evictCnt     (evictCnt),
    .snoopDropCnt (snoopDropCnt),
    .issuedCnt    (issuedCnt)
  );

  pf_prio_queue_dp #(
    .ADDR_W  (ADDR_W),
    .PRIO_W  (PRIO_W),
    .DEPTH   (DEPTH),
    .LATENCY (LATENCY),
    .TIME_W  (TIME_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .popGo       (popGo),
    .stb         (stb),
    .insAddr     (insAddr),
    .insPrio     (insPrio),
    .insSecure   (insSecure),
    .headReady   (headReady),
    .headAddr    (issueAddr),
    .headPrio    (issuePrio),
    .headSecure  (issueSecure),
    .matchFound  (matchFound),
    .matchPrio   (matchPrio),
    .postPopFull (postPopFull)
  );

endmodule

// File: rtl/pf_prio_queue_chk.sv
module pf_prio_queue_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgFilterEn,
  input logic             cfgSnoopEn,
  input logic             insValid,
  input logic             lookupHit,
  input logic             issueValid,
  input logic             issueReady,
  input logic [CNT_W-1:0] bufHitCnt,
  input logic [CNT_W-1:0] evictCnt,
  input logic [CNT_W-1:0] snoopDropCnt,
  input logic [CNT_W-1:0] issuedCnt
);

  // R9
  pop_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueReady) |=> (issuedCnt == $past(issuedCnt) + 1'b1));

  // R9
  no_pop_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issueValid && issueReady) |=> $stable(issuedCnt));

  // R4
  hit_needs_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insValid && cfgFilterEn) |=> $stable(bufHitCnt));

  // R8
  snoop_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insValid && cfgSnoopEn && lookupHit) |=> $stable(snoopDropCnt));

  // R7
  evict_needs_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insValid |=> $stable(evictCnt));

  // R10
  pop_frees_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insValid && issueValid && issueReady) |=> $stable(evictCnt));

endmodule

bind pf_prio_queue pf_prio_queue_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfgFilterEn  (cfgFilterEn),
  .cfgSnoopEn   (cfgSnoopEn),
  .insValid     (insValid),
  .lookupHit    (lookupHit),
  .issueValid   (issueValid),
  .issueReady   (issueReady),
  .bufHitCnt    (bufHitCnt),
  .evictCnt     (evictCnt),
  .snoopDropCnt (snoopDropCnt),
  .issuedCnt    (issuedCnt)
);

// File: tb/pf_prio_queue_test.sv
module pf_prio_queue_test;

  localparam int ADDR_W = 32;
  localparam int PRIO_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfgFilterEn = 1'b1;
  logic              cfgSnoopEn = 1'b0;
  logic              insValid = 1'b0;
  logic [ADDR_W-1:0] insAddr = '0;
  logic [PRIO_W-1:0] insPrio = '0;
  logic              insSecure = 1'b0;
  logic              lookupReq;
  logic [ADDR_W-1:0] lookupAddr;
  logic              lookupSecure;
  logic              lookupHit = 1'b0;
  logic              issueValid;
  logic              issueReady = 1'b0;
  logic [ADDR_W-1:0] issueAddr;
  logic [PRIO_W-1:0] issuePrio;
  logic              issueSecure;
  logic [CNT_W-1:0]  bufHitCnt, evictCnt, snoopDropCnt, issuedCnt;

  int nChecks = 0;
  int nFails  = 0;
  int expHit = 0, expEvict = 0, expSnoop = 0, expIssued = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pf_prio_queue #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfgFilterEn(cfgFilterEn), .cfgSnoopEn(cfgSnoopEn),
    .insValid(insValid), .insAddr(insAddr), .insPrio(insPrio), .insSecure(insSecure),
    .lookupReq(lookupReq), .lookupAddr(lookupAddr), .lookupSecure(lookupSecure),
    .lookupHit(lookupHit), .issueValid(issueValid), .issueReady(issueReady),
    .issueAddr(issueAddr), .issuePrio(issuePrio), .issueSecure(issueSecure),
    .bufHitCnt(bufHitCnt), .evictCnt(evictCnt), .snoopDropCnt(snoopDropCnt),
    .issuedCnt(issuedCnt)
  );

  // Ordering vectors: kind 0 = insert, 1 = pop (addr/prio are then the expected head)
  localparam int NVEC = 14;
  localparam int vKind [NVEC] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 1, 1};
  localparam int vAddr [NVEC] = '{'h100, 'h140, 'h180, 'h1c0, 'h1c0, 'h140, 'h100, 'h180,
                                  'h200, 'h240, 'h280, 'h240, 'h200, 'h280};
  localparam int vPrio [NVEC] = '{2, 5, 2, 7, 7, 5, 2, 2, -3, 0, -3, 0, -3, -3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic doIns(input int addr, input int prio, input bit sec, input bit hit);
    @(negedge clk);
    insValid  = 1'b1;
    insAddr   = ADDR_W'(addr);
    insPrio   = PRIO_W'(prio);
    insSecure = sec;
    lookupHit = hit;
    @(negedge clk);
    insValid  = 1'b0;
    lookupHit = 1'b0;
  endtask

  task automatic doPop(input int addr, input int prio, input string req);
    @(negedge clk);
    check(issueValid == 1'b1, req, int'(issueValid), 1);
    check(issueAddr == ADDR_W'(addr), req, int'(issueAddr), addr);
    check(issuePrio == PRIO_W'(prio), req, int'($signed(issuePrio)), prio);
    if (issueValid) begin
      issueReady = 1'b1;
      expIssued++;
      @(negedge clk);
      issueReady = 1'b0;
    end
  endtask

  task automatic checkEmpty(input string req);
    @(negedge clk);
    check(issueValid == 1'b0, req, int'(issueValid), 0);
  endtask

  task automatic checkCounters(input string req);
    check(int'(bufHitCnt) == expHit, {req, " bufHitCnt"}, int'(bufHitCnt), expHit);
    check(int'(evictCnt) == expEvict, {req, " evictCnt"}, int'(evictCnt), expEvict);
    check(int'(snoopDropCnt) == expSnoop, {req, " snoopDropCnt"}, int'(snoopDropCnt), expSnoop);
    check(int'(issuedCnt) == expIssued, {req, " issuedCnt"}, int'(issuedCnt), expIssued);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(issueValid == 1'b0, "R1 issueValid", int'(issueValid), 0);
    check(lookupReq == 1'b0, "R1 lookupReq", int'(lookupReq), 0);
    checkCounters("R1");

    // R2 ordering from the vector table
    for (int v = 0; v < NVEC; v++) begin
      if (vKind[v] == 0) doIns(vAddr[v], vPrio[v], 1'b0, 1'b0);
      else               doPop(vAddr[v], vPrio[v], "R2 order");
    end
    checkEmpty("R2 drained");

    // R3 readiness one cycle after the insert edge
    @(negedge clk);
    insValid = 1'b1; insAddr = 'h300; insPrio = 8'd1; insSecure = 1'b1;
    #1 check(issueValid == 1'b0, "R3 before insert", int'(issueValid), 0);
    @(negedge clk);
    insValid = 1'b0; insSecure = 1'b0;
    check(issueValid == 1'b1, "R3 valid after insert", int'(issueValid), 1);
    check(issueSecure == 1'b1, "R3 secure flag", int'(issueSecure), 1);
    doPop('h300, 1, "R3 head");

    // R4/R5 duplicate with higher priority promotes behind equals
    doIns('h400, 1, 1'b0, 1'b0);
    doIns('h440, 3, 1'b0, 1'b0);
    doIns('h480, 3, 1'b0, 1'b0);
    doIns('h400, 3, 1'b0, 1'b0);
    expHit++;
    @(negedge clk) checkCounters("R4 dup higher");
    doPop('h440, 3, "R5 promote order");
    doPop('h480, 3, "R5 promote order");
    doPop('h400, 3, "R5 promoted entry");
    checkEmpty("R4 no extra entry");

    // R5 duplicate with lower priority leaves entry untouched
    doIns('h500, 1, 1'b0, 1'b0);
    doIns('h540, 4, 1'b0, 1'b0);
    doIns('h500, 0, 1'b0, 1'b0);
    expHit++;
    doPop('h540, 4, "R5 lower dup");
    doPop('h500, 1, "R5 lower dup keeps prio");
    checkEmpty("R5 no extra entry");

    // R4 different secure flag is not a duplicate
    doIns('h600, 2, 1'b0, 1'b0);
    doIns('h600, 2, 1'b1, 1'b0);
    @(negedge clk) checkCounters("R4 secure differs");
    doPop('h600, 2, "R4 secure pair");
    check(issueSecure == 1'b1, "R4 second entry secure", int'(issueSecure), 1);
    doPop('h600, 2, "R4 secure pair");

    // R6 filter disabled
    cfgFilterEn = 1'b0;
    doIns('h700, 2, 1'b0, 1'b0);
    doIns('h700, 2, 1'b0, 1'b0);
    @(negedge clk) checkCounters("R6 filter off");
    doPop('h700, 2, "R6 first copy");
    doPop('h700, 2, "R6 second copy");
    checkEmpty("R6 drained");
    cfgFilterEn = 1'b1;

    // R7 full queue evicts oldest of lowest level
    doIns('h800, 3, 1'b0, 1'b0);
    doIns('h840, 1, 1'b0, 1'b0);
    doIns('h880, 1, 1'b0, 1'b0);
    doIns('h8c0, 1, 1'b0, 1'b0);
    doIns('h900, 2, 1'b0, 1'b0);
    expEvict++;
    @(negedge clk) checkCounters("R7 evict");
    doPop('h800, 3, "R7 order");
    doPop('h900, 2, "R7 new entry");
    doPop('h880, 1, "R7 victim was 0x840");
    doPop('h8c0, 1, "R7 order");
    checkEmpty("R7 drained");

    // R8 snoop drop, lookup request, ignore when disabled, duplicate first
    cfgSnoopEn = 1'b1;
    @(negedge clk);
    insValid = 1'b1; insAddr = 'ha00; insPrio = 8'd1; lookupHit = 1'b1;
    #1 check(lookupReq == 1'b1, "R8 lookupReq", int'(lookupReq), 1);
    check(lookupAddr == ADDR_W'('ha00), "R8 lookupAddr", int'(lookupAddr), 'ha00);
    @(negedge clk);
    insValid = 1'b0; lookupHit = 1'b0;
    expSnoop++;
    check(issueValid == 1'b0, "R8 dropped", int'(issueValid), 0);
    checkCounters("R8 snoop drop");
    cfgSnoopEn = 1'b0;
    doIns('ha40, 1, 1'b0, 1'b1);
    doPop('ha40, 1, "R8 hit ignored when off");
    cfgSnoopEn = 1'b1;
    doIns('ha80, 1, 1'b0, 1'b0);
    doIns('ha80, 2, 1'b0, 1'b1);
    expHit++;
    @(negedge clk) checkCounters("R8 dup before snoop");
    doPop('ha80, 2, "R8 dup promoted");
    cfgSnoopEn = 1'b0;

    // R9 pop on empty has no effect
    @(negedge clk);
    issueReady = 1'b1;
    @(negedge clk);
    issueReady = 1'b0;
    checkCounters("R9 empty pop");
    check(issueValid == 1'b0, "R9 still empty", int'(issueValid), 0);

    // R10 pop and insert in the same cycle on a full queue
    doIns('hb00, 5, 1'b0, 1'b0);
    doIns('hb40, 4, 1'b0, 1'b0);
    doIns('hb80, 3, 1'b0, 1'b0);
    doIns('hbc0, 2, 1'b0, 1'b0);
    @(negedge clk);
    check(issueAddr == ADDR_W'('hb00), "R10 head", int'(issueAddr), 'hb00);
    issueReady = 1'b1;
    insValid = 1'b1; insAddr = 'hc00; insPrio = 8'd1;
    @(negedge clk);
    issueReady = 1'b0; insValid = 1'b0;
    expIssued++;
    checkCounters("R10 no evict");
    doPop('hb40, 4, "R10 order");
    doPop('hb80, 3, "R10 order");
    doPop('hbc0, 2, "R10 order");
    doPop('hc00, 1, "R10 new entry kept");
    checkEmpty("R10 drained");
    @(negedge clk) checkCounters("R9 final");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule